// File: doc/BRIEF.md
# Circular Buffer with Per-Entry Fault Skipping

This block is a first-in first-out ring buffer whose physical array is larger than the depth it promises. Every physical slot has one bit in a fault map. When the bit is set, the slot is deconfigured. The write pointer and the read pointer both step over deconfigured slots, so those slots are never written and never read. The next-healthy-slot search finishes within the same cycle as the push or pop that needs it. Because of this, a deconfigured slot costs no extra cycle of access time.

With the default parameters there are 16 physical slots and a nominal depth of 12, which leaves 4 cold spares. As long as at least 12 slots are healthy, the buffer holds 12 items. After the spares are used up, the capacity falls to the number of healthy slots. A new fault map is taken only while the buffer holds nothing. An update that arrives while entries are stored is ignored, so a live entry is never stranded in a slot that has just been deconfigured.

Control is a four-state machine. `S_EMPTY` means no entries are held. `S_PARTIAL` means some entries are held but fewer than capacity. `S_FULL` means the occupancy equals capacity. `S_DEAD` means the capacity is zero. The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| T_FILL_FIRST | S_EMPTY | S_PARTIAL | Accepted push when capacity is above 1 |
| T_FILL_ONE | S_EMPTY | S_FULL | Accepted push when capacity is 1 |
| T_TOP_OFF | S_PARTIAL | S_FULL | Push without pop brings occupancy to capacity |
| T_DRAIN_LAST | S_PARTIAL | S_EMPTY | Pop without push removes the last entry |
| T_UNFILL | S_FULL | S_PARTIAL | Accepted pop when capacity is above 1 |
| T_UNFILL_ONE | S_FULL | S_EMPTY | Accepted pop when capacity is 1 |
| T_KILL | S_EMPTY | S_DEAD | Accepted map update that leaves no healthy slot |
| T_REVIVE | S_DEAD | S_EMPTY | Accepted map update that leaves at least one healthy slot |

Top module: `fmr_ring_buffer`

## Requirements
- R1: After reset, `empty`=1, `full`=0, the fault map is all zeros and `capacity`=12.
- R2: `capacity` equals the smaller of 12 and the number of zero bits in the accepted fault map, where bit i of `fmap_wdata` set to 1 marks physical slot i faulty.
- R3: Entries leave in the order they were accepted, for any fault map, across any number of pointer wraparounds.
- R4: A slot whose fault bit is 1 is never written and never read.
- R5: `full` is 1 exactly when occupancy equals capacity. While full, a push is refused, and a push offered together with a pop lets only the pop happen.
- R6: `empty` is 1 exactly when occupancy is zero, and a pop while empty is refused.
- R7: An update through `fmap_we` takes effect only while the buffer is empty. Otherwise it is ignored and `capacity` does not change. A push in the same cycle as an accepted update is refused.
- R8: With every slot faulty, `capacity`=0, `full` and `empty` are both 1, and pushes and pops are refused.
- R9: Once more than 4 slots are faulty, the buffer accepts exactly as many pushes as there are healthy slots before `full` rises.
- R10: In `S_PARTIAL`, a simultaneous push and pop both take effect and the occupancy is unchanged.
- R11: A push can be accepted every cycle and a pop can be accepted every cycle, even across runs of consecutive faulty slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Request to write `push_data` at the tail |
| push_data | input | DATA_W | Data written on an accepted push |
| pop | input | 1 | Request to remove the head entry |
| pop_data | output | DATA_W | Contents of the head entry; meaningful while not empty |
| fmap_we | input | 1 | Request to replace the fault map |
| fmap_wdata | input | PHYS_ENTRIES | New fault map; bit i = 1 marks slot i faulty |
| full | output | 1 | Occupancy equals capacity |
| empty | output | 1 | Occupancy is zero |
| capacity | output | $clog2(PHYS_ENTRIES+1) | Current usable depth |

## Verification
`full`, `empty` and `capacity` are all registered, so each of them reflects a push, pop or map update one rising edge after the cycle that carries it. `pop_data` is read combinationally from the registered head pointer, so it shows the new head in the cycle after a pop or after the first push into an empty buffer. The bench changes inputs on the falling edge and samples the flags 1 ns after the rising edge. It compares `pop_data` with its own queue model just before the edge that pops. The expected capacity for each fault map is computed arithmetically from the number of set bits.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
    typedef enum logic [1:0] {
        S_EMPTY   = 2'd0,
        S_PARTIAL = 2'd1,
        S_FULL    = 2'd2,
        S_DEAD    = 2'd3
    } fmr_state_e;
endpackage

// File: rtl/fmr_skip_finder.sv
// Finds the first healthy slot starting at start (inclusive) or just after it,
// wrapping modulo N, in pure combinational logic.
module fmr_skip_finder #(
    parameter int unsigned N  = 16,
    localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  fault,
    input  logic [PW-1:0] start,
    input  logic          inclusive,
    output logic [PW-1:0] nxt,
    output logic          found
);
    function automatic logic [PW-1:0] wrap_idx(input int unsigned v);
        return (v >= N) ? PW'(v - N) : PW'(v);
    endfunction

    int unsigned step;

    always_comb begin
        step  = inclusive ? 32'd0 : 32'd1;
        nxt   = start;
        found = 1'b0;
        // scan from the farthest offset down so the nearest healthy slot wins
        for (int o = N - 1; o >= 0; o--) begin
            if (!fault[wrap_idx(32'(start) + 32'(o) + step)]) begin
                nxt   = wrap_idx(32'(start) + 32'(o) + step);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fmr_capacity.sv
// Usable depth: min(nominal depth, number of healthy slots).
module fmr_capacity #(
    parameter int unsigned N       = 16,
    parameter int unsigned NOMINAL = 12,
    localparam int unsigned CW     = $clog2(N + 1)
) (
    input  logic [N-1:0]  fault,
    output logic [CW-1:0] cap
);
    logic [CW-1:0] healthy;

    always_comb begin
        healthy = '0;
        for (int i = 0; i < N; i++) begin
            healthy = healthy + CW'(!fault[i]);
        end
        cap = (healthy < CW'(NOMINAL)) ? healthy : CW'(NOMINAL);
    end
endmodule

// File: rtl/fmr_storage.sv
// Physical slot array, one register per slot, single write and single read port.
module fmr_storage #(
    parameter int unsigned N      = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_q [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == PW'(g))) begin
                slot_q[g] <= wdata;
            end
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/fmr_ring_buffer.sv
module fmr_ring_buffer
    import fmr_pkg::*;
#(
    parameter int unsigned PHYS_ENTRIES  = 16,
    parameter int unsigned NOMINAL_DEPTH = 12,
    parameter int unsigned DATA_W        = 8,
    localparam int unsigned PW = (PHYS_ENTRIES > 1) ? $clog2(PHYS_ENTRIES) : 1,
    localparam int unsigned CW = $clog2(PHYS_ENTRIES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic [DATA_W-1:0]       push_data,
    input  logic                    pop,
    output logic [DATA_W-1:0]       pop_data,
    input  logic                    fmap_we,
    input  logic [PHYS_ENTRIES-1:0] fmap_wdata,
    output logic                    full,
    output logic                    empty,
    output logic [CW-1:0]           capacity
);
    fmr_state_e state_q, state_d;

    logic [PHYS_ENTRIES-1:0] fmap_q;
    logic [PW-1:0]           head_q, tail_q;
    logic [CW-1:0]           cnt_q, cnt_d;
    logic [CW-1:0]           cap_cur, cap_new;
    logic [PW-1:0]           head_nxt, tail_nxt, align_pos;
    logic                    head_found, tail_found, align_found;
    logic                    upd_fire, push_fire, pop_fire;

    // ---------------- capacity of the live map and of the offered map
    fmr_capacity #(.N(PHYS_ENTRIES), .NOMINAL(NOMINAL_DEPTH)) u_cap_cur (
        .fault (fmap_q),
        .cap   (cap_cur)
    );

    fmr_capacity #(.N(PHYS_ENTRIES), .NOMINAL(NOMINAL_DEPTH)) u_cap_new (
        .fault (fmap_wdata),
        .cap   (cap_new)
    );

    // ---------------- single-cycle skip logic for both pointers
    fmr_skip_finder #(.N(PHYS_ENTRIES)) u_tail_step (
        .fault     (fmap_q),
        .start     (tail_q),
        .inclusive (1'b0),
        .nxt       (tail_nxt),
        .found     (tail_found)
    );

    fmr_skip_finder #(.N(PHYS_ENTRIES)) u_head_step (
        .fault     (fmap_q),
        .start     (head_q),
        .inclusive (1'b0),
        .nxt       (head_nxt),
        .found     (head_found)
    );

    // realignment of both pointers onto a healthy slot of the new map
    fmr_skip_finder #(.N(PHYS_ENTRIES)) u_align (
        .fault     (fmap_wdata),
        .start     (head_q),
        .inclusive (1'b1),
        .nxt       (align_pos),
        .found     (align_found)
    );

    // ---------------- acceptance
    assign upd_fire  = fmap_we && (cnt_q == '0);
    assign push_fire = push && !upd_fire && (cnt_q < cap_cur);
    assign pop_fire  = pop && !upd_fire && (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (push_fire && !pop_fire) begin
            cnt_d = cnt_q + 1'b1;
        end else if (pop_fire && !push_fire) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // ---------------- storage
    fmr_storage #(.N(PHYS_ENTRIES), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (push_fire),
        .waddr (tail_q),
        .wdata (push_data),
        .raddr (head_q),
        .rdata (pop_data)
    );

    // ---------------- datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmap_q <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (upd_fire) begin
                fmap_q <= fmap_wdata;
                head_q <= align_found ? align_pos : '0;
                tail_q <= align_found ? align_pos : '0;
            end else begin
                if (push_fire && tail_found) begin
                    tail_q <= tail_nxt;
                end
                if (pop_fire && head_found) begin
                    head_q <= head_nxt;
                end
            end
        end
    end

    // ---------------- state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: begin
                if (upd_fire && (cap_new == '0)) begin
                    state_d = S_DEAD;                                   // T_KILL
                end else if (push_fire) begin
                    state_d = (cap_cur == CW'(1)) ? S_FULL : S_PARTIAL; // T_FILL_ONE / T_FILL_FIRST
                end
            end
            S_PARTIAL: begin
                if (push_fire && !pop_fire && (cnt_q + 1'b1 == cap_cur)) begin
                    state_d = S_FULL;                                   // T_TOP_OFF
                end else if (pop_fire && !push_fire && (cnt_q == CW'(1))) begin
                    state_d = S_EMPTY;                                  // T_DRAIN_LAST
                end
            end
            S_FULL: begin
                if (pop_fire) begin
                    state_d = (cap_cur == CW'(1)) ? S_EMPTY : S_PARTIAL; // T_UNFILL_ONE / T_UNFILL
                end
            end
            S_DEAD: begin
                if (upd_fire && (cap_new != '0)) begin
                    state_d = S_EMPTY;                                  // T_REVIVE
                end
            end
            default: state_d = S_EMPTY;
        endcase
    end

    // ---------------- output decode
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state_q)
            S_EMPTY:   begin empty = 1'b1; full = 1'b0; end
            S_PARTIAL: begin empty = 1'b0; full = 1'b0; end
            S_FULL:    begin empty = 1'b0; full = 1'b1; end
            S_DEAD:    begin empty = 1'b1; full = 1'b1; end
            default:   begin empty = 1'b1; full = 1'b0; end
        endcase
    end

    assign capacity = cap_cur;

    // ---------------- assertions
    assert_no_write_faulty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_fire |-> !fmap_q[tail_q]);

    assert_no_read_faulty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_fire |-> !fmap_q[head_q]);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cap_cur);

    assert_full_matches_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FULL) |-> (cnt_q == cap_cur));

    assert_full_refuses_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (cnt_q == $past(cnt_q)));

    assert_empty_matches_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMPTY) |-> (cnt_q == '0));

    assert_empty_refuses_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

    assert_map_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> $stable(fmap_q));

    assert_dead_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_cur == '0) |-> (full && empty));

    assert_swap_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PARTIAL && push && pop && !fmap_we) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: tb/tb_fmr_ring_buffer.sv
`timescale 1ns/1ps
module tb_fmr_ring_buffer;
    localparam int PHYS = 16;
    localparam int NOM  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            push = 1'b0;
    logic [7:0]      push_data = '0;
    logic            pop = 1'b0;
    logic [7:0]      pop_data;
    logic            fmap_we = 1'b0;
    logic [PHYS-1:0] fmap_wdata = '0;
    logic            full, empty;
    logic [4:0]      capacity;

    always #5 clk = ~clk;

    fmr_ring_buffer #(.PHYS_ENTRIES(PHYS), .NOMINAL_DEPTH(NOM), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .fmap_we(fmap_we), .fmap_wdata(fmap_wdata),
        .full(full), .empty(empty), .capacity(capacity)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [7:0] mq[$];
    logic [PHYS-1:0] mmap = '0;

    function automatic int exp_cap(input logic [PHYS-1:0] m);
        int h = PHYS - $countones(m);
        return (h < NOM) ? h : NOM;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // one cycle of stimulus, with the model updated and the flags checked
    task automatic op(input bit p, input logic [7:0] d, input bit o,
                      input bit w, input logic [PHYS-1:0] m, input string tag);
        bit upd, pacc, oacc;
        int sz = mq.size();
        upd  = w && (sz == 0);
        pacc = p && !upd && (sz < exp_cap(mmap));
        oacc = o && !upd && (sz > 0);
        if (oacc) chk(pop_data == mq[0], {tag, " R3 pop order"}, pop_data, mq[0]);
        @(negedge clk);
        push = p; push_data = d; pop = o; fmap_we = w; fmap_wdata = m;
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0; fmap_we = 1'b0;
        if (oacc) void'(mq.pop_front());
        if (pacc) mq.push_back(d);
        if (upd) mmap = m;
        chk(capacity == 5'(exp_cap(mmap)), {tag, " R2 capacity"}, capacity, exp_cap(mmap));
        chk(full == (mq.size() == exp_cap(mmap)), {tag, " R5 full"}, full, mq.size() == exp_cap(mmap));
        chk(empty == (mq.size() == 0), {tag, " R6 empty"}, empty, mq.size() == 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: reset state
        chk(empty == 1'b1, "R1 empty", empty, 1);
        chk(full == 1'b0, "R1 full", full, 0);
        chk(capacity == 5'd12, "R1 capacity", capacity, 12);

        // R2 R3 R4 R8 R9 R11: sweep over the number of faulty slots
        for (int k = 0; k <= PHYS + 1; k++) begin
            logic [PHYS-1:0] m = '0;
            int c;
            if (k == PHYS + 1) m = 16'hC003;   // run of faults across the wrap point
            else for (int i = 0; i < PHYS; i++) if (((i * 7 + k * 3) % PHYS) < k) m[i] = 1'b1;
            op(0, 0, 0, 1, m, "R2 update");
            c = exp_cap(m);
            if (c == 0) begin
                chk(full && empty, "R8 dead flags", {full, empty}, 3);
                op(1, 8'h55, 0, 0, m, "R8 push refused");
                op(0, 0, 1, 0, m, "R8 pop refused");
                chk(empty && full, "R8 still dead", {full, empty}, 3);
            end
            for (int r = 0; r < 3; r++) begin
                for (int j = 0; j < c + 2; j++) begin
                    op(1, 8'(k * 16 + r * 5 + j), 0, 0, m, "R11 burst push");
                    if (j == c - 1) chk(full == 1'b1, "R9 full at healthy count", full, 1);
                end
                chk(mq.size() == c, "R5 overflow refused", mq.size(), c);
                for (int j = 0; j < c + 1; j++) op(0, 0, 1, 0, m, "R4 burst pop");
                chk(empty == 1'b1, "R6 drained", empty, 1);
            end
        end

        // R7: update ignored while entries are held
        op(0, 0, 0, 1, 16'h0000, "R7 clear map");
        for (int j = 0; j < 3; j++) op(1, 8'hA0 + 8'(j), 0, 0, 16'h0, "R7 fill");
        op(0, 0, 0, 1, 16'h00FF, "R7 update while busy");
        chk(capacity == 5'd12, "R7 capacity unchanged", capacity, 12);
        op(1, 8'hA3, 0, 0, 16'h0, "R7 push after ignored update");
        for (int j = 0; j < 4; j++) op(0, 0, 1, 0, 16'h0, "R7 drain");
        // R7: push alongside an accepted update is refused
        op(1, 8'hEE, 0, 1, 16'h0F0F, "R7 push with update");
        chk(empty == 1'b1, "R7 push refused on update", empty, 1);
        chk(capacity == 5'd8, "R7 new capacity", capacity, 8);

        // R10: simultaneous push and pop in the partial state
        op(1, 8'h10, 0, 0, 16'h0F0F, "R10 prime");
        op(1, 8'h11, 0, 0, 16'h0F0F, "R10 prime");
        for (int j = 0; j < 10; j++) begin
            op(1, 8'h20 + 8'(j), 1, 0, 16'h0F0F, "R10 swap");
            chk(mq.size() == 2 && !full && !empty, "R10 occupancy kept", mq.size(), 2);
        end
        // R5: at full, a push with a pop lets only the pop through
        for (int j = 0; j < 6; j++) op(1, 8'h40 + 8'(j), 0, 0, 16'h0F0F, "R5 fill");
        chk(full == 1'b1, "R5 full", full, 1);
        op(1, 8'h77, 1, 0, 16'h0F0F, "R5 push+pop at full");
        chk(full == 1'b0 && mq.size() == 7, "R5 only pop taken", full, 0);
        for (int j = 0; j < 8; j++) op(0, 0, 1, 0, 16'h0F0F, "R5 drain");
        chk(empty == 1'b1, "R6 final empty", empty, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule